// File: doc/BRIEF.md
# Prescaled match timer with PWM

The block is a free-running up-counter paced by a programmable prescaler. A prescale counter divides the clock. Each time it wraps, the timer count advances by one. Four match channels compare the count against their own match values. On a match, a channel can raise an interrupt flag, clear the count at the end of the current prescaled tick, or stop the timer. The actions are chosen per channel.

Any channel can instead shape a pulse-width waveform. The channel whose reset action is enabled sets the period. Every channel enabled for PWM goes high when the count passes its match value and goes low again when the count returns to zero. Software reaches everything through a plain register bus with write and read strobes. The outputs are a level interrupt and one output per channel.

Top module: `pwm_match_timer`

## Requirements
- R1: The prescale counter runs from 0 up to the prescale value (address 1) and then wraps to 0. The timer count (read at address 5) rises by one only on that wrap, so a prescale of 2 advances it once every 3 clocks. Both counters hold while control bit 0 (run) is 0.
- R2: When a channel's reset bit is set (match-control bit 3*ch+1), the count keeps the matched value for the whole prescaled tick and becomes 0 after it. With prescale 2 and match 6 the count reads 4, 5, 6, 0, 1.
- R3: When a channel's interrupt bit is set (match-control bit 3*ch), its flag (bit ch at address 4) is set on the clock after the first cycle in which the count equals its match value (address 8+ch). A match is detected once per tick. The `irq` output is high while any flag is set.
- R4: When a channel's stop bit is set (match-control bit 3*ch+2), the run bit reads 0 from the clock after the match, in the same cycle the flag rises. The count stays at the matched value.
- R5: When one channel has both reset and stop, stop wins: the timer halts at the matched value. The deferred clear is applied on the first tick after run is written to 1 again. Every channel that matches in the same tick sets its own flag.
- R6: Writing 1 to a flag bit at address 4 clears that flag. Bits written 0 leave their flags unchanged.
- R7: While control bit 1 (clear) is 1, the prescale counter and the timer count are held at 0, and all channel outputs go low.
- R8: For a channel whose bit is set in the PWM mask (address 3), the output goes high one clock after that channel's match. It goes low one clock after the count's first cycle at 0. A match value of 0 keeps the output high. A match value equal to or above the period channel's match value keeps it low.
- R9: For a channel not in the PWM mask, the output is a one-clock pulse on the clock after each match, whatever its match-control bits are.
- R10: Register layout: 0 control {clear, run}, 1 prescale, 2 match control, 3 PWM mask, 4 flags, 5 count, 8 to 11 match values. Every register reads 0 after reset, and `rdata` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; enables `rdata` |
| addr | input | ADDR_W | Register word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data (combinational) |
| irq | output | 1 | Level interrupt, high while any flag is pending |
| mat_out | output | N_CH | Per-channel match pulse or PWM output |

## Verification
The bench builds the block with its default parameters: a 32-bit count, four channels and a 4-bit address. It uses prescale values of 2 and 0. With a prescale of 2, the deferred clear and the once-per-tick match rule show up as three-cycle count steps. With a prescale of 0, a tick and a match fall in the same cycle, which brings the stop-over-reset priority and the pending clear on restart within reach. Small match values keep several full PWM periods and counter wraps inside a short run, so each cycle's count, interrupt and outputs can be compared against values computed in the bench.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  // register word addresses
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_PRESC  = 1;
  localparam int unsigned A_MCTL   = 2;
  localparam int unsigned A_PWMEN  = 3;
  localparam int unsigned A_FLAGS  = 4;
  localparam int unsigned A_COUNT  = 5;
  localparam int unsigned A_MATCH0 = 8;
  // control word bits
  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_CLR = 1;
  // match-control field layout, per channel
  localparam int unsigned MC_BITS  = 3;
  localparam int unsigned MC_IRQ   = 0;
  localparam int unsigned MC_RST   = 1;
  localparam int unsigned MC_STOP  = 2;
endpackage

// File: rtl/pmt_rst_sync.sv
module pmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [CNT_W-1:0]               wdata,
  output logic [CNT_W-1:0]               rdata,
  input  logic [CNT_W-1:0]               tc,
  input  logic [N_CH-1:0]                flag_set,
  input  logic                           stop_hit,
  output logic                           run_q,
  output logic                           clr_q,
  output logic [CNT_W-1:0]               pr_q,
  output logic [MC_BITS*N_CH-1:0]        mctl_q,
  output logic [N_CH-1:0]                pwm_en_q,
  output logic [N_CH-1:0][CNT_W-1:0]     mr_q,
  output logic [N_CH-1:0]                flags_q
);
  localparam int unsigned MW = MC_BITS * N_CH;

  logic                       run_d, clr_d;
  logic [CNT_W-1:0]           pr_d;
  logic [MW-1:0]              mctl_d;
  logic [N_CH-1:0]            pwm_en_d;
  logic [N_CH-1:0][CNT_W-1:0] mr_d;
  logic [N_CH-1:0]            flags_d;
  logic [N_CH-1:0]            w1c_mask;

  // next state
  always_comb begin
    run_d    = run_q;
    clr_d    = clr_q;
    pr_d     = pr_q;
    mctl_d   = mctl_q;
    pwm_en_d = pwm_en_q;
    mr_d     = mr_q;
    if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        run_d = wdata[CTRL_RUN];
        clr_d = wdata[CTRL_CLR];
      end
      if (addr == ADDR_W'(A_PRESC)) pr_d     = wdata;
      if (addr == ADDR_W'(A_MCTL))  mctl_d   = wdata[MW-1:0];
      if (addr == ADDR_W'(A_PWMEN)) pwm_en_d = wdata[N_CH-1:0];
      for (int i = 0; i < N_CH; i++) begin
        if (addr == ADDR_W'(A_MATCH0 + i)) mr_d[i] = wdata;
      end
    end
    // a stop action overrides a software write of the run bit
    if (stop_hit) run_d = 1'b0;
    w1c_mask = (wr_en && addr == ADDR_W'(A_FLAGS)) ? wdata[N_CH-1:0] : '0;
    flags_d  = (flags_q & ~w1c_mask) | flag_set;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      clr_q    <= 1'b0;
      pr_q     <= '0;
      mctl_q   <= '0;
      pwm_en_q <= '0;
      mr_q     <= '0;
      flags_q  <= '0;
    end else begin
      run_q    <= run_d;
      clr_q    <= clr_d;
      pr_q     <= pr_d;
      mctl_q   <= mctl_d;
      pwm_en_q <= pwm_en_d;
      mr_q     <= mr_d;
      flags_q  <= flags_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        rdata[CTRL_RUN] = run_q;
        rdata[CTRL_CLR] = clr_q;
      end
      if (addr == ADDR_W'(A_PRESC)) rdata           = pr_q;
      if (addr == ADDR_W'(A_MCTL))  rdata[MW-1:0]   = mctl_q;
      if (addr == ADDR_W'(A_PWMEN)) rdata[N_CH-1:0] = pwm_en_q;
      if (addr == ADDR_W'(A_FLAGS)) rdata[N_CH-1:0] = flags_q;
      if (addr == ADDR_W'(A_COUNT)) rdata           = tc;
      for (int i = 0; i < N_CH; i++) begin
        if (addr == ADDR_W'(A_MATCH0 + i)) rdata = mr_q[i];
      end
    end
  end
endmodule

// File: rtl/pmt_count.sv
module pmt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] pr,
  input  logic             stop_hit,
  input  logic             rst_hit,
  output logic [CNT_W-1:0] pc_q,
  output logic [CNT_W-1:0] tc_q,
  output logic             first
);
  logic [CNT_W-1:0] pc_d, tc_d;
  logic             fresh_q, fresh_d;   // count value not yet compared
  logic             pend_q, pend_d;     // clear deferred to end of tick
  logic             active, tick;

  assign active = run & ~clr;
  // ">=" keeps a lowered prescale from stranding the prescale counter
  assign tick   = active & (pc_q >= pr);
  assign first  = active & fresh_q;

  always_comb begin
    pc_d    = pc_q;
    tc_d    = tc_q;
    fresh_d = fresh_q;
    pend_d  = pend_q;
    if (clr) begin
      pc_d    = '0;
      tc_d    = '0;
      fresh_d = 1'b1;
      pend_d  = 1'b0;
    end else if (active) begin
      pc_d = tick ? '0 : pc_q + CNT_W'(1);
      if (tick && !stop_hit) begin
        tc_d    = (pend_q || rst_hit) ? '0 : tc_q + CNT_W'(1);
        fresh_d = 1'b1;
        pend_d  = 1'b0;
      end else begin
        fresh_d = 1'b0;
        pend_d  = pend_q | rst_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      tc_q    <= '0;
      fresh_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      tc_q    <= tc_d;
      fresh_q <= fresh_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/pmt_match.sv
module pmt_match
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       first,
  input  logic [CNT_W-1:0]           tc,
  input  logic [N_CH-1:0][CNT_W-1:0] mr,
  input  logic [MC_BITS*N_CH-1:0]    mctl,
  input  logic [N_CH-1:0]            pwm_en,
  output logic [N_CH-1:0]            evt,
  output logic [N_CH-1:0]            flag_set,
  output logic                       stop_hit,
  output logic                       rst_hit,
  output logic [N_CH-1:0]            mat_out
);
  logic [N_CH-1:0] irq_en, rst_en, stop_en;
  logic [N_CH-1:0] out_d, out_q, below;
  logic            has_per, cyc_start;
  logic [CNT_W-1:0] per_val;

  // period comes from the lowest-numbered channel with reset enabled
  always_comb begin
    has_per = 1'b0;
    per_val = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (rst_en[i]) begin
        has_per = 1'b1;
        per_val = mr[i];
      end
    end
  end

  assign cyc_start = first & (tc == '0);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign irq_en[g]  = mctl[g*MC_BITS + MC_IRQ];
    assign rst_en[g]  = mctl[g*MC_BITS + MC_RST];
    assign stop_en[g] = mctl[g*MC_BITS + MC_STOP];
    assign evt[g]     = first & (tc == mr[g]);
    assign below[g]   = ~has_per | (mr[g] < per_val);
    // PWM: set on match (wins over cycle start), clear at cycle start
    assign out_d[g]   = clr       ? 1'b0 :
                        !pwm_en[g] ? evt[g] :
                        (evt[g] && below[g]) ? 1'b1 :
                        cyc_start ? 1'b0 : out_q[g];
  end

  assign flag_set = evt & irq_en;
  assign stop_hit = |(evt & stop_en);
  assign rst_hit  = |(evt & rst_en);
  assign mat_out  = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic [N_CH-1:0]   mat_out
);
  localparam int unsigned MW = MC_BITS * N_CH;

  logic                       rst_sync_n;
  logic                       run_q, clr_q, first, stop_hit, rst_hit;
  logic [CNT_W-1:0]           pr_q, pc_q, tc_q;
  logic [MW-1:0]              mctl_q;
  logic [N_CH-1:0]            pwm_en_q, flags_q, flag_set, match_evt;
  logic [N_CH-1:0][CNT_W-1:0] mr_q;

  pmt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmt_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .tc       (tc_q),
    .flag_set (flag_set),
    .stop_hit (stop_hit),
    .run_q    (run_q),
    .clr_q    (clr_q),
    .pr_q     (pr_q),
    .mctl_q   (mctl_q),
    .pwm_en_q (pwm_en_q),
    .mr_q     (mr_q),
    .flags_q  (flags_q)
  );

  pmt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_q),
    .clr      (clr_q),
    .pr       (pr_q),
    .stop_hit (stop_hit),
    .rst_hit  (rst_hit),
    .pc_q     (pc_q),
    .tc_q     (tc_q),
    .first    (first)
  );

  pmt_match #(.CNT_W(CNT_W), .N_CH(N_CH)) u_match (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr_q),
    .first    (first),
    .tc       (tc_q),
    .mr       (mr_q),
    .mctl     (mctl_q),
    .pwm_en   (pwm_en_q),
    .evt      (match_evt),
    .flag_set (flag_set),
    .stop_hit (stop_hit),
    .rst_hit  (rst_hit),
    .mat_out  (mat_out)
  );

  assign irq = |flags_q;
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CH  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             clr_q,
  input logic [CNT_W-1:0] pr_q,
  input logic [CNT_W-1:0] pc_q,
  input logic [CNT_W-1:0] tc_q,
  input logic [N_CH-1:0]  flag_set,
  input logic             stop_hit,
  input logic [N_CH-1:0]  flags_q
);
  assert_prescale_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !clr_q && pc_q >= pr_q) |=> (pc_q == '0));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !clr_q && pc_q < pr_q) |=> $stable(tc_q));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_q) |=> $stable(tc_q));

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  assert_stop_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !run_q);

  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> $stable(tc_q));

  assert_clear_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (tc_q == '0 && pc_q == '0));
endmodule

bind pwm_match_timer pmt_checker #(.CNT_W(CNT_W), .N_CH(N_CH)) u_pmt_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run_q    (run_q),
  .clr_q    (clr_q),
  .pr_q     (pr_q),
  .pc_q     (pc_q),
  .tc_q     (tc_q),
  .flag_set (flag_set),
  .stop_hit (stop_hit),
  .flags_q  (flags_q)
);

// File: tb/tb_pwm_match_timer.sv
module tb_pwm_match_timer;
  logic        clk, rst_n, wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  logic [3:0]  mat_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] cnt;
    logic        irq;
    logic [3:0]  mo;
    string       req;
  } exp_t;
  exp_t q[$];
  exp_t mon_e;

  pwm_match_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .mat_out(mat_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: one expected item per clock, compared away from the edge
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      checks++;
      if (rdata !== mon_e.cnt || irq !== mon_e.irq || mat_out !== mon_e.mo) begin
        fails++;
        $display("FAIL %s: cnt=%0d irq=%b out=%b, expected cnt=%0d irq=%b out=%b",
                 mon_e.req, rdata, irq, mat_out, mon_e.cnt, mon_e.irq, mon_e.mo);
      end
    end
  end

  task automatic push(input logic [31:0] c, input logic i, input logic [3:0] m, input string r);
    exp_t e;
    e.cnt = c; e.irq = i; e.mo = m; e.req = r;
    q.push_back(e);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // write, then leave the bus reading the count (address 5)
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = 4'd5;
  endtask

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", r, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string r);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    #1;
    chk(r, rdata, exp);
    addr = 4'd5;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd_chk(4'd0, 32'h0, "R10 reset control");
    rd_chk(4'd1, 32'h0, "R10 reset prescale");
    rd_chk(4'd4, 32'h0, "R10 reset flags");
    chk("R3 reset irq", {31'b0, irq}, 32'h0);
    chk("R9 reset outputs", {28'b0, mat_out}, 32'h0);
    repeat (4) @(negedge clk);
    rd_chk(4'd5, 32'h0, "R1 count holds while run is 0");

    // A: prescale 2, ch0 match 6 with interrupt and reset
    wr(4'd0, 32'h2);
    wr(4'd4, 32'hF);
    wr(4'd1, 32'd2);
    wr(4'd8, 32'd6);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd10, 32'hFFFF_FFFF);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0);
    wr(4'd2, 32'h3);
    wr(4'd0, 32'h1);
    for (int j = 0; j < 45; j++)
      push((j / 3) % 7, j >= 19, {3'b000, (j >= 19) && ((j - 19) % 21 == 0)},
           "R1 R2 R3 R9 prescaled reset-on-match");
    drain();
    rd_chk(4'd4, 32'h1, "R3 flag register after match");
    rd_chk(4'd2, 32'h3, "R10 match control readback");
    rd_chk(4'd8, 32'd6, "R10 match value readback");
    @(negedge clk);
    rd_en = 1'b0; addr = 4'd1; #1;
    chk("R10 rdata zero while rd_en low", rdata, 32'h0);

    // B: prescale 2, ch1 match 6 with interrupt and stop
    wr(4'd0, 32'h2);
    wr(4'd4, 32'hF);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'd6);
    wr(4'd2, 32'h28);
    wr(4'd0, 32'h1);
    for (int j = 0; j < 30; j++)
      push((j < 18) ? j / 3 : 6, j >= 19, (j == 19) ? 4'b0010 : 4'b0000,
           "R4 stop-on-match");
    drain();
    rd_chk(4'd0, 32'h0, "R4 run bit cleared by stop");
    rd_chk(4'd4, 32'h2, "R3 flag of stopping channel");

    // C: prescale 0, ch0 irq and ch2 irq+reset+stop, both match 3
    wr(4'd0, 32'h2);
    wr(4'd4, 32'hF);
    wr(4'd1, 32'd0);
    wr(4'd8, 32'd3);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd10, 32'd3);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd2, 32'h1C1);
    wr(4'd0, 32'h1);
    for (int j = 0; j < 8; j++)
      push((j < 3) ? j : 3, j >= 4, (j == 4) ? 4'b0101 : 4'b0000,
           "R5 stop wins over reset");
    drain();
    rd_chk(4'd4, 32'h5, "R5 both matching channels flagged");
    rd_chk(4'd0, 32'h0, "R5 run cleared");
    wr(4'd0, 32'h1);
    push(3, 1'b1, 4'b0000, "R5 restart holds matched value one tick");
    push(0, 1'b1, 4'b0000, "R5 pending clear applied on restart");
    push(1, 1'b1, 4'b0000, "R5 count after restart");
    push(2, 1'b1, 4'b0000, "R5 count after restart");
    push(3, 1'b1, 4'b0000, "R5 second match");
    push(3, 1'b1, 4'b0101, "R5 second stop");
    push(3, 1'b1, 4'b0000, "R5 halted again");
    drain();
    wr(4'd4, 32'h1);
    rd_chk(4'd4, 32'h4, "R6 write-one clears only that flag");
    chk("R6 irq held by remaining flag", {31'b0, irq}, 32'h1);
    wr(4'd4, 32'h4);
    rd_chk(4'd4, 32'h0, "R6 last flag cleared");
    chk("R3 irq low with no flags", {31'b0, irq}, 32'h0);

    // D: PWM, prescale 0, ch3 period 9, ch0=6, ch1=0, ch2=9 (equal to period)
    wr(4'd0, 32'h2);
    wr(4'd4, 32'hF);
    wr(4'd1, 32'd0);
    wr(4'd8, 32'd6);
    wr(4'd9, 32'd0);
    wr(4'd10, 32'd9);
    wr(4'd11, 32'd9);
    wr(4'd2, 32'h400);
    wr(4'd3, 32'h7);
    wr(4'd0, 32'h1);
    for (int j = 0; j < 35; j++) begin
      int t;
      logic [3:0] m;
      t = j % 10;
      m[0] = (j >= 7) && (t >= 7 || t == 0);
      m[1] = (j >= 1);
      m[2] = 1'b0;
      m[3] = (j >= 10) && (t == 0);
      push(t, 1'b0, m, "R8 R9 PWM waveforms");
    end
    drain();

    // clear while running
    wr(4'd0, 32'h3);
    repeat (3) @(negedge clk);
    rd_chk(4'd5, 32'h0, "R7 count held at zero by clear");
    chk("R7 outputs low under clear", {28'b0, mat_out}, 32'h0);
    rd_chk(4'd0, 32'h3, "R10 control readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule